// File: doc/BRIEF.md
# ADC Power and Clock Mode Controller

This block holds the power state and the conversion clock mode of a successive-approximation converter core. The serial front end reports three events to it: a start bit was seen, a control byte was accepted (with its keep-powered bit and its clock-select bit), and a conversion finished. A three-level shutdown pin arrives as a two-bit code. From these the block derives whether the core and its reference are powered, which clock paces the conversion, and whether the serial port stays usable. It also drives a one-cycle abort when the pin cuts off a conversion that is running.

There are two ways to power down. A control byte whose keep-powered bit is clear lets the running conversion finish and only then drops the core. The next start bit wakes the core again. The shutdown pin works at once: it abandons any conversion and overrides whatever the control bytes asked for. The pin passes through a synchronizer first. A programmable wakeup counter holds a ready flag low after every power-up and after every time the reference is switched back on. A control byte accepted while the flag is low is reported as an invalid request.

Top module: `adc_pwr_clk_ctl`

## Requirements
- R1: During and right after reset the outputs read core_on=1, ref_on=1, ext_clk_mode=0 (internal clock), serial_on=1, ready=0, conv_busy=0, conv_abort=0.
- R2: A control byte with ctl_keep_on=0 leaves core_on at 1 while its conversion runs (conv_busy=1). core_on falls on the clock edge that takes conv_done.
- R3: While the core is down because of a control byte, a start_seen pulse sets core_on on that edge. The next byte's ctl_keep_on then decides the state after its conversion: 1 keeps the core up, 0 drops it again.
- R4: Pin codes: 2'b00 = low, 2'b01 = floating, 2'b10 = high, 2'b11 = floating. Low gives core_on=0 and ref_on=0. Floating gives ref_on=1. High gives ref_on=0. Core power under floating or high follows the control bytes.
- R5: When the pin goes low during a conversion, conv_abort is 1 for exactly one cycle, on the same edge where conv_busy and core_on fall. While the pin is low, control bytes change neither the clock mode nor conv_busy.
- R6: Every control byte accepted with the pin not low sets ext_clk_mode to its ctl_ext_clk bit (1 = external, 0 = internal). The mode holds until the next such byte.
- R7: ready rises WAKE_CYC edges after reset. It is 0 while the core is off. After the core or the reference is switched back on, it rises WAKE_CYC+1 edges after the edge that raised core_on or ref_on.
- R8: A control byte accepted while ready=0 raises req_invalid for one cycle on the next edge. A byte accepted while ready=1 does not.
- R9: A change on shdn_pin reaches core_on and ref_on on the (SYNC_STAGES+1)-th rising edge after it is applied, and on no earlier edge.
- R10: serial_on is 0 while the pin is low, and 0 while the core is down through a control byte in external clock mode. Otherwise it is 1, so a result can still be read in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Pulse: control byte accepted |
| ctl_keep_on | input | 1 | Keep-powered bit of that byte |
| ctl_ext_clk | input | 1 | Clock-select bit of that byte |
| start_seen | input | 1 | Pulse: start bit detected |
| conv_done | input | 1 | Pulse: conversion finished |
| shdn_pin | input | 2 | Asynchronous three-level shutdown code |
| core_on | output | 1 | Converter core powered |
| ref_on | output | 1 | Reference enabled |
| ext_clk_mode | output | 1 | 1 = external conversion clock |
| conv_abort | output | 1 | One-cycle abort of a running conversion |
| conv_busy | output | 1 | Conversion in progress |
| serial_on | output | 1 | Serial port usable |
| ready | output | 1 | Wakeup period elapsed |
| req_invalid | output | 1 | Byte accepted before ready |

## Verification
Some properties are checked on every cycle. The core stays powered while a conversion is busy. The abort never lasts two cycles. The clock mode changes only after an accepted byte. The ready flag never follows a cycle with the core off. A disabled serial port implies an unpowered core. Exact latencies can only be shown by the bench's scenarios: the synchronizer edge count, the wakeup count after reset, after a pin release and after a reference restart, and the invalid-request pulse. The bench also sweeps all four keep/clock combinations and all four pin codes.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    PIN_LOW       = 2'b00,
    PIN_FLOAT     = 2'b01,
    PIN_HIGH      = 2'b10,
    PIN_FLOAT_ALT = 2'b11
  } pin_lvl_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic core_on,
  input  logic ref_on,
  output logic ready
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC);

  logic [CW-1:0] cnt, cnt_n;
  logic core_d, ref_d, relaunch;

  always_comb begin
    relaunch = (core_on && !core_d) || (ref_on && !ref_d);
    if (!core_on || relaunch) cnt_n = LOAD;
    else if (cnt != '0)       cnt_n = cnt - CW'(1);
    else                      cnt_n = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= LOAD;
      core_d <= 1'b1;
      ref_d  <= 1'b1;
      ready  <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      core_d <= core_on;
      ref_d  <= ref_on;
      ready  <= core_on && (cnt_n == '0);
    end
  end

  // R7: ready only after a cycle with the core powered
  a_r7_ready_after_power: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(core_on));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import adc_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_lvl_t pin,
  input  logic     byte_ok,
  input  logic     keep_on,
  input  logic     ext_sel,
  input  logic     start_seen,
  input  logic     conv_done,
  input  logic     ready,
  output logic     core_on_q,
  output logic     ref_on_q,
  output logic     ext_q,
  output logic     abort_q,
  output logic     busy_q,
  output logic     if_on_q,
  output logic     bad_q
);
  logic soft_down, sleep_after;
  logic soft_down_n, sleep_after_n, busy_n, ext_n;
  logic pin_low, pin_float;

  always_comb begin
    pin_low       = (pin == PIN_LOW);
    pin_float     = (pin == PIN_FLOAT) || (pin == PIN_FLOAT_ALT);
    soft_down_n   = soft_down;
    sleep_after_n = sleep_after;
    busy_n        = busy_q;
    ext_n         = ext_q;
    if (pin_low) begin
      busy_n        = 1'b0;
      sleep_after_n = 1'b0;
    end else if (byte_ok) begin
      busy_n        = 1'b1;
      sleep_after_n = !keep_on;
      ext_n         = ext_sel;
      soft_down_n   = 1'b0;
    end else begin
      if (start_seen) soft_down_n = 1'b0;
      if (conv_done && busy_q) begin
        busy_n = 1'b0;
        if (sleep_after) soft_down_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_down   <= 1'b0;
      sleep_after <= 1'b0;
      busy_q      <= 1'b0;
      ext_q       <= 1'b0;
      core_on_q   <= 1'b1;
      ref_on_q    <= 1'b1;
      abort_q     <= 1'b0;
      if_on_q     <= 1'b1;
      bad_q       <= 1'b0;
    end else begin
      soft_down   <= soft_down_n;
      sleep_after <= sleep_after_n;
      busy_q      <= busy_n;
      ext_q       <= ext_n;
      core_on_q   <= !pin_low && !soft_down_n;
      ref_on_q    <= pin_float;
      abort_q     <= pin_low && busy_q;
      if_on_q     <= !pin_low && (!soft_down_n || !ext_n);
      bad_q       <= byte_ok && !ready;
    end
  end

  // R2: a running conversion always has its core powered
  a_r2_busy_keeps_core: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> core_on_q);
  // R5: abort is a single-cycle pulse
  a_r5_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q);
  // R6: clock mode moves only after an accepted byte
  a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_ok) |-> $stable(ext_q));
  // R10: a closed serial port implies an unpowered core
  a_r10_port_vs_core: assert property (@(posedge clk) disable iff (rst)
    !if_on_q |-> !core_on_q);
endmodule

// File: rtl/adc_pwr_clk_ctl.sv
module adc_pwr_clk_ctl
  import adc_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_valid,
  input  logic       ctl_keep_on,
  input  logic       ctl_ext_clk,
  input  logic       start_seen,
  input  logic       conv_done,
  input  logic [1:0] shdn_pin,
  output logic       core_on,
  output logic       ref_on,
  output logic       ext_clk_mode,
  output logic       conv_abort,
  output logic       conv_busy,
  output logic       serial_on,
  output logic       ready,
  output logic       req_invalid
);
  logic [1:0] pin_q;
  pin_lvl_t   pin_s;

  pwr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(PIN_FLOAT)) u_sync (
    .clk(clk), .rst(rst), .d(shdn_pin), .q(pin_q)
  );

  assign pin_s = pin_lvl_t'(pin_q);

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .pin(pin_s),
    .byte_ok(ctl_valid), .keep_on(ctl_keep_on), .ext_sel(ctl_ext_clk),
    .start_seen(start_seen), .conv_done(conv_done), .ready(ready),
    .core_on_q(core_on), .ref_on_q(ref_on), .ext_q(ext_clk_mode),
    .abort_q(conv_abort), .busy_q(conv_busy), .if_on_q(serial_on),
    .bad_q(req_invalid)
  );

  pwr_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst(rst), .core_on(core_on), .ref_on(ref_on), .ready(ready)
  );

  // R8: an invalid-request flag follows a cycle without ready
  a_r8_invalid_when_unready: assert property (@(posedge clk) disable iff (rst)
    req_invalid |-> !$past(ready));
endmodule

// File: tb/tb_adc_pwr_clk_ctl.sv
module tb_adc_pwr_clk_ctl;
  localparam int CLK_NS = 10;
  localparam int WAKE = 4;
  localparam int STG = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_valid = 0, ctl_keep_on = 0, ctl_ext_clk = 0, start_seen = 0, conv_done = 0;
  logic [1:0] shdn_pin = 2'b01;
  logic core_on, ref_on, ext_clk_mode, conv_abort, conv_busy, serial_on, ready, req_invalid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  adc_pwr_clk_ctl #(.SYNC_STAGES(STG), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_keep_on(ctl_keep_on),
    .ctl_ext_clk(ctl_ext_clk), .start_seen(start_seen), .conv_done(conv_done),
    .shdn_pin(shdn_pin), .core_on(core_on), .ref_on(ref_on),
    .ext_clk_mode(ext_clk_mode), .conv_abort(conv_abort), .conv_busy(conv_busy),
    .serial_on(serial_on), .ready(ready), .req_invalid(req_invalid)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_seen = 1; step(); start_seen = 0;
  endtask

  task automatic send_byte(logic k, logic e);
    ctl_valid = 1; ctl_keep_on = k; ctl_ext_clk = e; step(); ctl_valid = 0;
  endtask

  task automatic finish_conv();
    conv_done = 1; step(); conv_done = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    step(3);
    rst = 0;
    // R1 reset state
    chk("R1", "core_on", core_on, 1);
    chk("R1", "ref_on", ref_on, 1);
    chk("R1", "ext_clk_mode", ext_clk_mode, 0);
    chk("R1", "serial_on", serial_on, 1);
    chk("R1", "ready", ready, 0);
    chk("R1", "busy", conv_busy, 0);
    chk("R1", "abort", conv_abort, 0);
    // R7 ready after WAKE edges
    for (int j = 1; j <= WAKE; j++) begin
      step();
      chk("R7", "ready after reset", ready, j >= WAKE);
    end
    // R2 R3 R6 R10 sweep of keep/clock bits
    for (int k = 0; k < 2; k++) begin
      for (int e = 0; e < 2; e++) begin
        pulse_start();
        step(WAKE + 3);
        chk("R3", "woken by start", core_on, 1);
        send_byte(k[0], e[0]);
        chk("R6", "clock mode", ext_clk_mode, e[0]);
        chk("R2", "busy set", conv_busy, 1);
        chk("R8", "no invalid when ready", req_invalid, 0);
        step(3);
        chk("R2", "core up while busy", core_on, 1);
        finish_conv();
        chk("R2", "busy cleared", conv_busy, 0);
        chk("R3", "core after conversion", core_on, k[0]);
        chk("R10", "serial port", serial_on, k[0] || !e[0]);
      end
    end
    // R8 byte right after a wake, before ready
    pulse_start(); step(WAKE + 3);
    send_byte(0, 0); finish_conv();
    chk("R2", "down after keep=0", core_on, 0);
    pulse_start();
    chk("R3", "start wakes core", core_on, 1);
    send_byte(1, 0);
    chk("R8", "invalid pulse", req_invalid, 1);
    step();
    chk("R8", "invalid clears", req_invalid, 0);
    finish_conv();
    step(WAKE + 3);
    // R9 R5 pin low during a conversion
    send_byte(1, 1);
    shdn_pin = 2'b00;
    for (int j = 1; j <= STG; j++) begin
      step();
      chk("R9", "no early pin effect", core_on, 1);
    end
    step();
    chk("R9", "pin effect on time", core_on, 0);
    chk("R5", "abort pulse", conv_abort, 1);
    chk("R5", "busy dropped", conv_busy, 0);
    chk("R4", "ref off when low", ref_on, 0);
    step();
    chk("R5", "abort one cycle", conv_abort, 0);
    chk("R7", "not ready when off", ready, 0);
    send_byte(1, 0);
    step();
    chk("R5", "mode kept while low", ext_clk_mode, 1);
    chk("R5", "no conversion while low", conv_busy, 0);
    chk("R10", "port closed while low", serial_on, 0);
    // R4 sweep of all pin codes
    for (int v = 0; v < 4; v++) begin
      shdn_pin = v[1:0];
      step(STG + 1);
      chk("R4", "core by pin", core_on, v != 0);
      chk("R4", "ref by pin", ref_on, (v == 1) || (v == 3));
    end
    // R7 relaunch after reference re-enable
    shdn_pin = 2'b10;
    step(STG + WAKE + 4);
    chk("R7", "ready with ref off", ready, 1);
    shdn_pin = 2'b01;
    step(STG + 1);
    chk("R4", "ref back on", ref_on, 1);
    for (int j = STG + 2; j <= STG + 2 + WAKE; j++) begin
      step();
      chk("R7", "ready after ref restart", ready, j == STG + 2 + WAKE);
    end
    report();
  end
endmodule